// File: doc/BRIEF.md
# Converter Start/Handshake Capture Controller

This block sits on the digital side of a parallel analog-to-digital converter that is started by a short active-high pulse and reports completion with a data-available strobe. When the block is idle, a `sample_tick` makes it drive a start pulse whose width is a fixed number of system clocks. A check at elaboration confirms that this width, at the given clock period, is inside the window the converter allows. The block then waits for the converter's data-available line. It ignores further ticks until that line rises or until a programmable wait limit runs out. If the limit runs out, the block raises a one-cycle timeout.

The data-available line passes through a two-flop synchronizer and an edge detector. The data word and the out-of-range flag go through a pipeline of equal depth, so that each edge comes out together with the word that was present when that edge was sampled. On a rising edge the block latches the result, decodes overrange or underrange from the flag and the top data bit, and pulses `res_valid` for one cycle. On a falling edge it latches the word still on the bus, which is the earlier conversion's result, and pulses `prev_valid`.

Top module: `adc_handshake_ctrl`

## Requirements
- R1: One cycle after a `sample_tick` is sampled while idle, `adc_encode` goes high. It stays high for exactly ENC_CYCLES clock cycles (default 4, i.e. 20 ns at a 5 ns clock).
- R2: While `busy` is high, `sample_tick` is ignored. No new start pulse begins until a rising data-available edge has been detected or a timeout has occurred.
- R3: `res_valid` is high for exactly one cycle. It rises at the third clock edge that samples `adc_dav` high after a low sample.
- R4: `res_data` and `res_otr` take the values of `adc_data` and `adc_otr` sampled at the first clock edge that saw `adc_dav` high. They hold those values until the next capture.
- R5: `res_over` = `res_otr` AND `res_data[11]`, and `res_under` = `res_otr` AND NOT `res_data[11]`. Both are low when `res_otr` is low. Both update together with `res_data`.
- R6: `prev_valid` is high for exactly one cycle. It rises at the third clock edge that samples `adc_dav` low after a high sample. `prev_data` and `prev_otr` then hold the word and flag sampled at the last edge that saw `adc_dav` high.
- R7: `timeout_err` pulses for one cycle, and the block returns to idle, once the waiting phase has lasted `timeout_limit`+1 cycles with no rising edge detected. A rising edge detected in that final waiting cycle takes precedence, and then no timeout is raised.
- R8: A rising data-available edge is captured and reported on `res_valid` in any state, including after a timeout has already been raised.
- R9: During reset and after it, every output is 0. The synchronizer presets to data-available high, so a line that is already high at reset release produces no edge.
- R10: `busy` is high from the first start-pulse cycle through the last waiting cycle, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sample_tick | input | 1 | Request a conversion |
| timeout_limit | input | 16 | Waiting cycles before timeout, minus one |
| adc_encode | output | 1 | Start pulse to the converter |
| adc_dav | input | 1 | Data-available line from the converter (asynchronous) |
| adc_data | input | 12 | Converter data word |
| adc_otr | input | 1 | Converter out-of-range flag |
| busy | output | 1 | Conversion in progress |
| timeout_err | output | 1 | One-cycle pulse: conversion never completed |
| res_valid | output | 1 | One-cycle pulse: new result latched |
| res_data | output | 12 | Latched result word |
| res_otr | output | 1 | Latched out-of-range flag |
| res_over | output | 1 | Result above the input range |
| res_under | output | 1 | Result below the input range |
| prev_valid | output | 1 | One-cycle pulse: earlier result latched on falling edge |
| prev_data | output | 12 | Word present at the falling edge |
| prev_otr | output | 1 | Flag present at the falling edge |

## Verification
The wait counter reaching its limit and a synchronized rising edge can happen in the same cycle. That cycle decides between a timeout and a delivered result. The bench sets a small wait limit and steps the delay of the converter's reply across that boundary one cycle at a time, with one step landing the edge detection exactly on the limit cycle. A behavioural model compares every clock and expects the result to win in that cycle, with a timeout only on later replies, whose late result must still appear on `res_valid`.

// File: rtl/adc_ctrl_pkg.sv
// Shared types for the converter handshake controller.
package adc_ctrl_pkg;

    // Sequencer phases: idle, start pulse driven, waiting for completion.
    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_PULSE = 2'd1,
        SEQ_WAIT  = 2'd2
    } seq_state_t;

endpackage

// File: rtl/adc_dav_sync.sv
// Synchronizes the data-available line and detects its edges.
// The word bus (flag on top, data below) travels through a pipeline
// of the same depth, so each edge is reported with the word that was
// sampled alongside it. Assumes the word is stable for at least one clock
// around each data-available edge, as the converter's timing guarantees.
// Reset presets the line history to high (converter idle level).
module adc_dav_sync #(
    parameter int DATA_W      = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dav_async,
    input  logic [DATA_W:0]   word_async,
    output logic              dav_rise,
    output logic              dav_fall,
    output logic [DATA_W:0]   word_at_rise,
    output logic [DATA_W:0]   word_at_fall
);
    localparam int LAST = SYNC_STAGES;

    logic [LAST:0]   dav_pipe;
    logic [DATA_W:0] word_pipe [0:LAST];

    // Shift the data-available line through the sync flops plus one history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) dav_pipe <= '1;
        else        dav_pipe <= {dav_pipe[LAST-1:0], dav_async};
    end

    // One word pipeline stage per line stage, kept in step with the line.
    for (genvar i = 0; i <= LAST; i++) begin : g_word_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (!rst_n) word_pipe[0] <= '0;
                else        word_pipe[0] <= word_async;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (!rst_n) word_pipe[i] <= '0;
                else        word_pipe[i] <= word_pipe[i-1];
            end
        end
    end

    assign dav_rise     =  dav_pipe[LAST-1] & ~dav_pipe[LAST];
    assign dav_fall     = ~dav_pipe[LAST-1] &  dav_pipe[LAST];
    assign word_at_rise = word_pipe[LAST-1];
    assign word_at_fall = word_pipe[LAST];

endmodule

// File: rtl/adc_encode_seq.sv
// Start-pulse sequencer. From idle, a tick starts a pulse of ENC_CYCLES
// clocks, then the block waits for a detected rising edge. After
// timeout_limit+1 waiting cycles with no edge it pulses a timeout and
// returns to idle. An edge in the final waiting cycle wins over the timeout.
module adc_encode_seq
    import adc_ctrl_pkg::*;
#(
    parameter int ENC_CYCLES = 4,
    parameter int TO_W       = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sample_tick,
    input  logic [TO_W-1:0] timeout_limit,
    input  logic            dav_rise,
    output logic            encode,
    output logic            busy,
    output logic            timeout_pulse
);
    localparam int ENC_W = $clog2(ENC_CYCLES + 1);
    localparam int CNT_W = (TO_W > ENC_W) ? TO_W : ENC_W;
    localparam logic [CNT_W-1:0] ENC_LAST = CNT_W'(ENC_CYCLES - 1);
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

    seq_state_t       state;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] limit_ext;
    logic             enc_q;
    logic             to_q;

    assign limit_ext = CNT_W'(timeout_limit);

    // Phase transitions, pulse-width counting and wait-limit counting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SEQ_IDLE;
            cnt   <= '0;
            enc_q <= 1'b0;
            to_q  <= 1'b0;
        end else begin
            to_q <= 1'b0;
            unique case (state)
                SEQ_IDLE: begin
                    if (sample_tick) begin
                        state <= SEQ_PULSE;
                        cnt   <= '0;
                        enc_q <= 1'b1;
                    end
                end
                SEQ_PULSE: begin
                    if (cnt == ENC_LAST) begin
                        state <= SEQ_WAIT;
                        cnt   <= '0;
                        enc_q <= 1'b0;
                    end else begin
                        cnt <= cnt + CNT_ONE;
                    end
                end
                SEQ_WAIT: begin
                    if (dav_rise) begin
                        state <= SEQ_IDLE;
                        cnt   <= '0;
                    end else if (cnt == limit_ext) begin
                        state <= SEQ_IDLE;
                        cnt   <= '0;
                        to_q  <= 1'b1;
                    end else begin
                        cnt <= cnt + CNT_ONE;
                    end
                end
                default: begin
                    state <= SEQ_IDLE;
                    cnt   <= '0;
                    enc_q <= 1'b0;
                end
            endcase
        end
    end

    assign encode        = enc_q;
    assign busy          = (state != SEQ_IDLE);
    assign timeout_pulse = to_q;

endmodule

// File: rtl/adc_result_latch.sv
// Holds the latest result (captured on a rising edge) with its range
// decode, and the earlier result seen on a falling edge. Each capture
// comes with a one-cycle strobe. Word layout: bit DATA_W is the
// out-of-range flag and bit DATA_W-1 is the data MSB.
module adc_result_latch #(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dav_rise,
    input  logic              dav_fall,
    input  logic [DATA_W:0]   word_at_rise,
    input  logic [DATA_W:0]   word_at_fall,
    output logic              res_valid,
    output logic [DATA_W-1:0] res_data,
    output logic              res_otr,
    output logic              res_over,
    output logic              res_under,
    output logic              prev_valid,
    output logic [DATA_W-1:0] prev_data,
    output logic              prev_otr
);
    localparam int FLAG = DATA_W;
    localparam int MSB  = DATA_W - 1;

    // Latch the new result and decode its range on a rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_data  <= '0;
            res_otr   <= 1'b0;
            res_over  <= 1'b0;
            res_under <= 1'b0;
        end else begin
            res_valid <= dav_rise;
            if (dav_rise) begin
                res_data  <= word_at_rise[MSB:0];
                res_otr   <= word_at_rise[FLAG];
                res_over  <= word_at_rise[FLAG] &  word_at_rise[MSB];
                res_under <= word_at_rise[FLAG] & ~word_at_rise[MSB];
            end
        end
    end

    // Latch the word still on the bus when the line falls.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_valid <= 1'b0;
            prev_data  <= '0;
            prev_otr   <= 1'b0;
        end else begin
            prev_valid <= dav_fall;
            if (dav_fall) begin
                prev_data <= word_at_fall[MSB:0];
                prev_otr  <= word_at_fall[FLAG];
            end
        end
    end

endmodule

// File: rtl/adc_handshake_ctrl.sv
// Top of the converter handshake controller: start-pulse sequencer,
// data-available synchronizer and result latches. At elaboration it checks
// that ENC_CYCLES * CLK_PERIOD_PS is at least ENC_MIN_PS and below ENC_MAX_PS.
module adc_handshake_ctrl #(
    parameter int DATA_W        = 12,
    parameter int SYNC_STAGES   = 2,
    parameter int CLK_PERIOD_PS = 5000,
    parameter int ENC_CYCLES    = 4,
    parameter int ENC_MIN_PS    = 20000,
    parameter int ENC_MAX_PS    = 30000,
    parameter int TO_W          = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_tick,
    input  logic [TO_W-1:0]   timeout_limit,
    output logic              adc_encode,
    input  logic              adc_dav,
    input  logic [DATA_W-1:0] adc_data,
    input  logic              adc_otr,
    output logic              busy,
    output logic              timeout_err,
    output logic              res_valid,
    output logic [DATA_W-1:0] res_data,
    output logic              res_otr,
    output logic              res_over,
    output logic              res_under,
    output logic              prev_valid,
    output logic [DATA_W-1:0] prev_data,
    output logic              prev_otr
);
    localparam int ENC_PS = ENC_CYCLES * CLK_PERIOD_PS;

    if (ENC_CYCLES < 1 || ENC_PS < ENC_MIN_PS || ENC_PS >= ENC_MAX_PS) begin : g_bad_pulse_width
        $error("start pulse width %0d ps outside [%0d, %0d) ps", ENC_PS, ENC_MIN_PS, ENC_MAX_PS);
    end
    if (SYNC_STAGES < 2) begin : g_bad_sync_depth
        $error("synchronizer needs at least two stages");
    end

    logic            dav_rise;
    logic            dav_fall;
    logic [DATA_W:0] word_at_rise;
    logic [DATA_W:0] word_at_fall;

    adc_dav_sync #(
        .DATA_W      (DATA_W),
        .SYNC_STAGES (SYNC_STAGES)
    ) i_sync (
        .clk          (clk),
        .rst_n        (rst_n),
        .dav_async    (adc_dav),
        .word_async   ({adc_otr, adc_data}),
        .dav_rise     (dav_rise),
        .dav_fall     (dav_fall),
        .word_at_rise (word_at_rise),
        .word_at_fall (word_at_fall)
    );

    adc_encode_seq #(
        .ENC_CYCLES (ENC_CYCLES),
        .TO_W       (TO_W)
    ) i_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .sample_tick   (sample_tick),
        .timeout_limit (timeout_limit),
        .dav_rise      (dav_rise),
        .encode        (adc_encode),
        .busy          (busy),
        .timeout_pulse (timeout_err)
    );

    adc_result_latch #(
        .DATA_W (DATA_W)
    ) i_latch (
        .clk          (clk),
        .rst_n        (rst_n),
        .dav_rise     (dav_rise),
        .dav_fall     (dav_fall),
        .word_at_rise (word_at_rise),
        .word_at_fall (word_at_fall),
        .res_valid    (res_valid),
        .res_data     (res_data),
        .res_otr      (res_otr),
        .res_over     (res_over),
        .res_under    (res_under),
        .prev_valid   (prev_valid),
        .prev_data    (prev_data),
        .prev_otr     (prev_otr)
    );

endmodule

// File: rtl/adc_handshake_ctrl_chk.sv
// Property checker for adc_handshake_ctrl, bound to every instance.
// Looks only at the top module's ports, plus a run counter for the pulse width.
module adc_handshake_ctrl_chk #(
    parameter int DATA_W     = 12,
    parameter int ENC_CYCLES = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              adc_encode,
    input logic              busy,
    input logic              timeout_err,
    input logic              res_valid,
    input logic [DATA_W-1:0] res_data,
    input logic              res_otr,
    input logic              res_over,
    input logic              res_under,
    input logic              prev_valid
);
    localparam int RUN_W = $clog2(ENC_CYCLES + 2) + 1;

    logic [RUN_W-1:0] run;

    // Count consecutive cycles with the start pulse high.
    always_ff @(posedge clk) begin
        if (!rst_n)          run <= '0;
        else if (adc_encode) run <= run + RUN_W'(1);
        else                 run <= '0;
    end

    assert_enc_width_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(adc_encode) |-> (run == RUN_W'(ENC_CYCLES)));

    assert_start_from_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(adc_encode) |-> $past(!busy));

    assert_valid_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);

    assert_result_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> ($stable(res_data) && $stable(res_otr)));

    assert_over_decode_R5: assert property (@(posedge clk) disable iff (!rst_n)
        res_over |-> (res_otr && res_data[DATA_W-1]));

    assert_under_decode_R5: assert property (@(posedge clk) disable iff (!rst_n)
        res_under |-> (res_otr && !res_data[DATA_W-1]));

    assert_in_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !res_otr |-> !(res_over || res_under));

    assert_prev_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        prev_valid |=> !prev_valid);

    assert_timeout_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_err |-> (!busy && !res_valid));

    assert_busy_cover_R10: assert property (@(posedge clk) disable iff (!rst_n)
        adc_encode |-> busy);

endmodule

bind adc_handshake_ctrl adc_handshake_ctrl_chk #(
    .DATA_W     (DATA_W),
    .ENC_CYCLES (ENC_CYCLES)
) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .adc_encode  (adc_encode),
    .busy        (busy),
    .timeout_err (timeout_err),
    .res_valid   (res_valid),
    .res_data    (res_data),
    .res_otr     (res_otr),
    .res_over    (res_over),
    .res_under   (res_under),
    .prev_valid  (prev_valid)
);

// File: tb/test_adc_handshake_ctrl.sv
`timescale 1ns/1ps
// Bench: a behavioural reference model compared on every clock, a scripted
// converter, and explicit checks for each requirement.
module test_adc_handshake_ctrl;
    localparam int ENC = 4;
    localparam int DW  = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick = 1'b0;
    logic [15:0]   limit = 16'd200;
    logic          dav = 1'b1;
    logic [DW-1:0] data = '0;
    logic          otr = 1'b0;

    logic          adc_encode, busy, timeout_err, res_valid, res_otr, res_over, res_under;
    logic          prev_valid, prev_otr;
    logic [DW-1:0] res_data, prev_data;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;
    int enc_starts = 0;
    bit compare_on = 0;
    logic enc_seen = 1'b0;

    always #2.5 clk = ~clk;

    adc_handshake_ctrl #(.ENC_CYCLES(ENC)) i_adc_handshake_ctrl (
        .clk(clk), .rst_n(rst_n), .sample_tick(tick), .timeout_limit(limit),
        .adc_encode(adc_encode), .adc_dav(dav), .adc_data(data), .adc_otr(otr),
        .busy(busy), .timeout_err(timeout_err), .res_valid(res_valid),
        .res_data(res_data), .res_otr(res_otr), .res_over(res_over),
        .res_under(res_under), .prev_valid(prev_valid), .prev_data(prev_data),
        .prev_otr(prev_otr)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h at cycle %0d", req, what, act, exp, cyc);
        end
    endtask

    // ---------------- reference model ----------------
    bit          hist_dav[$];
    logic [12:0] hist_word[$];
    int  m_mode = 0;
    int  m_k = 0;
    logic e_enc = 0, e_busy = 0, e_rv = 0, e_ro = 0, e_over = 0, e_under = 0, e_pv = 0, e_po = 0, e_to = 0;
    logic [DW-1:0] e_rd = '0, e_pd = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            hist_dav  = '{1'b1, 1'b1, 1'b1};
            hist_word = '{13'd0, 13'd0, 13'd0};
            m_mode = 0; m_k = 0;
            {e_enc, e_busy, e_rv, e_ro, e_over, e_under, e_pv, e_po, e_to} = '0;
            e_rd = '0; e_pd = '0;
        end else begin
            bit rise, fall;
            rise = hist_dav[1] && !hist_dav[2];
            fall = !hist_dav[1] && hist_dav[2];
            e_rv = rise;
            if (rise) begin
                e_rd    = hist_word[1][DW-1:0];
                e_ro    = hist_word[1][DW];
                e_over  = e_ro && e_rd[DW-1];
                e_under = e_ro && !e_rd[DW-1];
            end
            e_pv = fall;
            if (fall) begin
                e_pd = hist_word[2][DW-1:0];
                e_po = hist_word[2][DW];
            end
            e_to = 1'b0;
            if (m_mode == 0) begin
                if (tick) begin m_mode = 1; m_k = 0; end
            end else if (m_mode == 1) begin
                if (m_k == ENC - 1) begin m_mode = 2; m_k = 0; end
                else m_k++;
            end else begin
                if (rise) m_mode = 0;
                else if (m_k == int'(limit)) begin e_to = 1'b1; m_mode = 0; end
                else m_k++;
            end
            e_enc  = (m_mode == 1);
            e_busy = (m_mode != 0);
            hist_dav.push_front(dav);   void'(hist_dav.pop_back());
            hist_word.push_front({otr, data}); void'(hist_word.pop_back());
        end
    end

    // Compare every output with the model away from the active edge.
    always @(negedge clk) begin
        if (compare_on) begin
            chk("R1",  "adc_encode",  adc_encode,  e_enc);
            chk("R10", "busy",        busy,        e_busy);
            chk("R3",  "res_valid",   res_valid,   e_rv);
            chk("R4",  "res_data",    res_data,    e_rd);
            chk("R4",  "res_otr",     res_otr,     e_ro);
            chk("R5",  "res_over",    res_over,    e_over);
            chk("R5",  "res_under",   res_under,   e_under);
            chk("R6",  "prev_valid",  prev_valid,  e_pv);
            chk("R6",  "prev_data",   prev_data,   e_pd);
            chk("R6",  "prev_otr",    prev_otr,    e_po);
            chk("R7",  "timeout_err", timeout_err, e_to);
        end
    end

    // Count start-pulse rising edges seen at the port.
    always @(posedge clk) begin
        cyc++;
        if (adc_encode && !enc_seen) enc_starts++;
        enc_seen <= adc_encode;
        if (cyc > 150000) begin
            n_fail++;
            $display("FAIL R7 watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    // One conversion: tick, measure the pulse, answer after the given delays.
    task automatic conv(input int fall_dly, input int conv_dly, input logic [DW-1:0] val,
                        input logic o, input bit spam_tick);
        int n;
        int starts0;
        starts0 = enc_starts;
        tick = 1'b1;
        @(negedge clk);
        if (!spam_tick) tick = 1'b0;
        n = 0;
        while (adc_encode && n < 100) begin n++; @(negedge clk); end
        chk("R1", "pulse width", n, ENC);
        repeat (fall_dly) @(negedge clk);
        dav = 1'b0;
        repeat (conv_dly) @(negedge clk);
        data = val; otr = o;
        repeat (2) @(negedge clk);
        tick = 1'b0;
        dav = 1'b1;
        repeat (3) @(negedge clk);
        chk("R8", "res_valid after reply", res_valid, 1'b1);
        chk("R4", "res_data value", res_data, val);
        chk("R5", "over decode", res_over, o & val[DW-1]);
        chk("R5", "under decode", res_under, o & ~val[DW-1]);
        chk("R2", "one start per conversion", enc_starts - starts0, 1);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        int m;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        compare_on = 1;
        @(negedge clk);
        chk("R9", "encode after reset", adc_encode, 1'b0);
        chk("R9", "busy after reset", busy, 1'b0);
        chk("R9", "res_data after reset", res_data, 0);
        repeat (3) @(negedge clk);
        chk("R9", "no edge with line high", res_valid | prev_valid | timeout_err, 1'b0);

        // Normal conversions with several word and flag patterns.
        conv(2, 10, 12'h000, 1'b0, 0);
        conv(1, 20, 12'hABC, 1'b0, 0);
        chk("R6", "earlier word on falling edge", prev_data, 12'h000);
        conv(3, 15, 12'hFFF, 1'b1, 0);
        conv(2, 12, 12'h000, 1'b1, 0);
        conv(2, 8,  12'h800, 1'b1, 1);
        conv(2, 30, 12'h7FF, 1'b0, 1);
        conv(2, 9,  12'h5A5, 1'b0, 1);
        chk("R6", "earlier flag on falling edge", prev_otr, 1'b0);

        // Timeout with no reply, then a late reply.
        limit = 16'd10;
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        m = 1;
        while (!timeout_err && m < 200) begin m++; @(negedge clk); end
        chk("R7", "timeout cycle", m, 10 + 6);
        chk("R7", "idle after timeout", busy, 1'b0);
        repeat (3) @(negedge clk);
        dav = 1'b0;
        repeat (4) @(negedge clk);
        data = 12'h3C3; otr = 1'b0;
        repeat (2) @(negedge clk);
        dav = 1'b1;
        repeat (3) @(negedge clk);
        chk("R8", "late result reported", res_valid, 1'b1);
        chk("R8", "late result word", res_data, 12'h3C3);
        repeat (3) @(negedge clk);

        // Sweep the reply across the wait limit; d = limit-6 ties exactly.
        limit = 16'd12;
        for (int d = 3; d <= 9; d++) begin
            conv(2, d, 12'(16'h100 + d), 1'b0, 0);
            chk("R7", "boundary: no timeout pending", busy, 1'b0);
        end

        repeat (10) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule